// File: doc/BRIEF.md
# Video-Bus Memory Decoder

This block is the cartridge-side glue between a console video processor and the two memories that can answer its 14-bit address bus. One is the console's 2KB internal video RAM, which has an active-low enable. The other is the cartridge pattern memory, which has an active-high enable. In every cycle the block decodes the address and a static wiring mode. From these it drives both enables and the address presented to each memory. It also holds behavioural models of both memories, so that bytes written over the bus can be read back one cycle later.

Three wiring schemes are offered. Split mode sends the low 8KB of the map to the cartridge and the upper 8KB to internal RAM. Four-screen mode switches internal RAM off, and the cartridge memory then holds both tiles and name/attribute tables. Single-chip mode never enables the cartridge, so internal RAM answers everywhere and its 2KB repeat across the map. The 256-byte palette page at 0x3F00–0x3FFF belongs to the video processor itself, and neither memory responds to it. The cartridge memory is a parameter: 8KB or 16KB, RAM or ROM.

Read data comes back through a small tracking state machine with three states. TRK_IDLE means no byte is due and returns 0xFF. TRK_INT returns the internal RAM byte. TRK_CART returns the cartridge byte. From any state, the machine moves to TRK_INT on a read that enables internal RAM. It moves to TRK_CART on a read that enables the cartridge. Otherwise it moves to TRK_IDLE.

Top module: `vbd_top`

## Requirements
- R1: With mode 0 (split), an address with bit 13 low gives cart_en=1 and int_ce_n=1. An address with bit 13 high that is outside the palette page gives int_ce_n=0 and cart_en=0. The two enables are never active together in any mode.
- R2: With mode 1 (four-screen), int_ce_n is 1 for every address, and cart_en is 1 for every address outside the palette page.
- R3: With mode 2 (single-chip), cart_en is 0 for every address, and int_ce_n is 0 for every address outside the palette page.
- R4: For addresses 0x3F00–0x3FFF, int_ce_n=1 and cart_en=0 in every mode. A write there changes no stored byte, and a read there returns 0xFF.
- R5: int_addr equals address bits 10:0 in every mode, so the 2KB internal RAM repeats every 0x800 bytes (for example, 0x2000 and 0x2800 hit the same byte).
- R6: cart_addr equals the low log2(CART_KB*1024) address bits. With an 8KB memory, addresses 0x0010 and 0x2010 hit the same byte. With 16KB they are distinct.
- R7: Mode 3 decodes exactly like mode 0.
- R8: A read strobe in cycle N makes rdata, in cycle N+1, equal to the stored byte of whichever memory was enabled for that address in cycle N.
- R9: rdata is 0xFF in the cycle after any cycle with no read strobe, and in the cycle after a read that enabled no memory.
- R10: A write strobe stores wdata in the enabled memory only if no read strobe is active in the same cycle. A cartridge memory built as ROM (CART_IS_RAM=0) ignores writes and returns address[7:0] XOR address[13:8] for its masked address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the read tracker |
| mode | input | 2 | Wiring scheme: 0 split, 1 four-screen, 2 single-chip, 3 same as split |
| vaddr | input | 14 | Video bus address |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| int_ce_n | output | 1 | Internal video RAM enable, active low |
| cart_en | output | 1 | Cartridge pattern memory enable, active high |
| int_addr | output | 11 | Address presented to internal RAM |
| cart_addr | output | CART_AW | Address presented to cartridge memory (13 bits at the default size) |
| rdata | output | 8 | Read data, one cycle after the read strobe; 0xFF when no byte is due |

## Verification
The hardest behaviour to bring about is a write that is dropped: the palette page aliases internal RAM byte 0x705, and a simultaneous read and write must leave the cartridge byte intact. These effects show only when the same location is later read through a different, enabled address. The stimulus therefore first stores a known byte at 0x2705 and then writes a different byte at 0x3F05. It also moves between modes, so that a byte written as name-table data in four-screen mode is read back as pattern data in split mode. Each read is checked against a bench-side shadow of both memories. The decode outputs are swept across all 16K addresses in all four mode codes, on both a default 8KB RAM build and a 16KB ROM build.

// File: rtl/vbd_pkg.sv
package vbd_pkg;

    localparam int VA_W   = 14;
    localparam int DW     = 8;
    localparam int INT_AW = 11;

    localparam logic [DW-1:0] IDLE_BYTE = 8'hFF;
    localparam logic [5:0]    PAL_PAGE  = 6'h3F;

    typedef enum logic [1:0] {
        VB_SPLIT  = 2'd0,
        VB_FOUR   = 2'd1,
        VB_SINGLE = 2'd2,
        VB_ALT    = 2'd3
    } vb_mode_e;

    typedef enum logic [1:0] {
        TRK_IDLE = 2'd0,
        TRK_INT  = 2'd1,
        TRK_CART = 2'd2
    } trk_state_e;

    // Generated contents of the read-only cartridge variant.
    function automatic logic [DW-1:0] rom_byte(input logic [VA_W-1:0] a);
        return a[7:0] ^ {2'b00, a[13:8]};
    endfunction

endpackage

// File: rtl/vbd_decode.sv
module vbd_decode
    import vbd_pkg::*;
#(
    parameter int CART_AW = 13
) (
    input  logic [1:0]         mode,
    input  logic [VA_W-1:0]    vaddr,
    output logic               int_ce_n,
    output logic               cart_en,
    output logic [INT_AW-1:0]  int_addr,
    output logic [CART_AW-1:0] cart_addr
);

    vb_mode_e sel;
    logic     in_pal;
    logic     in_names;

    always_comb begin
        sel      = vb_mode_e'(mode);
        in_pal   = (vaddr[VA_W-1:8] == PAL_PAGE);
        in_names = vaddr[VA_W-1];
        int_ce_n = 1'b1;
        cart_en  = 1'b0;
        unique case (sel)
            VB_FOUR: begin
                int_ce_n = 1'b1;
                cart_en  = !in_pal;
            end
            VB_SINGLE: begin
                int_ce_n = in_pal;
                cart_en  = 1'b0;
            end
            VB_SPLIT, VB_ALT: begin
                int_ce_n = !in_names || in_pal;
                cart_en  = !in_names;
            end
            default: begin
                int_ce_n = 1'b1;
                cart_en  = 1'b0;
            end
        endcase
    end

    // Name-table page bit followed by the in-page offset.
    assign int_addr  = {vaddr[10], vaddr[9:0]};
    assign cart_addr = vaddr[CART_AW-1:0];

endmodule

// File: rtl/vbd_int_ram.sv
module vbd_int_ram
    import vbd_pkg::*;
#(
    parameter int AW = INT_AW
) (
    input  logic          clk,
    input  logic          ce_n,
    input  logic          rd,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (!ce_n) begin
            if (rd) begin
                rdata <= mem[addr];
            end else if (wr) begin
                mem[addr] <= wdata;
            end
        end
    end

endmodule

// File: rtl/vbd_cart_mem.sv
module vbd_cart_mem
    import vbd_pkg::*;
#(
    parameter int AW     = 13,
    parameter bit IS_RAM = 1'b1,
    parameter int LANE_W = 2
) (
    input  logic          clk,
    input  logic          en,
    input  logic          rd,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    localparam int LANES = 1 << LANE_W;
    localparam int WORDS = 1 << (AW - LANE_W);

    generate
        if (IS_RAM) begin : g_ram
            logic [DW*LANES-1:0] mem [WORDS];
            logic [DW*LANES-1:0] q_word;
            logic [LANE_W-1:0]   q_lane;

            always_ff @(posedge clk) begin
                if (en) begin
                    if (rd) begin
                        q_word <= mem[addr[AW-1:LANE_W]];
                        q_lane <= addr[LANE_W-1:0];
                    end else if (wr) begin
                        mem[addr[AW-1:LANE_W]][addr[LANE_W-1:0]*DW +: DW] <= wdata;
                    end
                end
            end

            assign rdata = q_word[q_lane*DW +: DW];
        end else begin : g_rom
            logic [DW-1:0] q_byte;

            always_ff @(posedge clk) begin
                if (en && rd) begin
                    q_byte <= rom_byte(VA_W'(addr));
                end
            end

            assign rdata = q_byte;
        end
    endgenerate

endmodule

// File: rtl/vbd_rd_track.sv
module vbd_rd_track
    import vbd_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd,
    input  logic          int_ce_n,
    input  logic          cart_en,
    input  logic [DW-1:0] int_q,
    input  logic [DW-1:0] cart_q,
    output logic [DW-1:0] rdata
);

    trk_state_e state;
    trk_state_e state_nxt;
    trk_state_e pick;

    always_comb begin
        if (!rd) begin
            pick = TRK_IDLE;
        end else if (!int_ce_n) begin
            pick = TRK_INT;
        end else if (cart_en) begin
            pick = TRK_CART;
        end else begin
            pick = TRK_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= TRK_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        unique case (state)
            TRK_IDLE: state_nxt = pick;
            TRK_INT:  state_nxt = pick;
            TRK_CART: state_nxt = pick;
            default:  state_nxt = TRK_IDLE;
        endcase
    end

    always_comb begin
        unique case (state)
            TRK_INT:  rdata = int_q;
            TRK_CART: rdata = cart_q;
            default:  rdata = IDLE_BYTE;
        endcase
    end

    AST_TRK_INT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !int_ce_n) |=> (state == TRK_INT)); // R8
    AST_TRK_CART: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && cart_en && int_ce_n) |=> (state == TRK_CART)); // R8

endmodule

// File: rtl/vbd_top.sv
module vbd_top
    import vbd_pkg::*;
#(
    parameter int  CART_KB     = 8,
    parameter bit  CART_IS_RAM = 1'b1,
    localparam int CART_AW     = $clog2(CART_KB * 1024)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         mode,
    input  logic [13:0]        vaddr,
    input  logic               rd,
    input  logic               wr,
    input  logic [7:0]         wdata,
    output logic               int_ce_n,
    output logic               cart_en,
    output logic [10:0]        int_addr,
    output logic [CART_AW-1:0] cart_addr,
    output logic [7:0]         rdata
);

    logic [DW-1:0] int_q;
    logic [DW-1:0] cart_q;

    vbd_decode #(
        .CART_AW(CART_AW)
    ) decode_i (
        .mode      (mode),
        .vaddr     (vaddr),
        .int_ce_n  (int_ce_n),
        .cart_en   (cart_en),
        .int_addr  (int_addr),
        .cart_addr (cart_addr)
    );

    vbd_int_ram #(
        .AW(INT_AW)
    ) int_ram_i (
        .clk   (clk),
        .ce_n  (int_ce_n),
        .rd    (rd),
        .wr    (wr),
        .addr  (int_addr),
        .wdata (wdata),
        .rdata (int_q)
    );

    vbd_cart_mem #(
        .AW     (CART_AW),
        .IS_RAM (CART_IS_RAM),
        .LANE_W (2)
    ) cart_mem_i (
        .clk   (clk),
        .en    (cart_en),
        .rd    (rd),
        .wr    (wr),
        .addr  (cart_addr),
        .wdata (wdata),
        .rdata (cart_q)
    );

    vbd_rd_track track_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd       (rd),
        .int_ce_n (int_ce_n),
        .cart_en  (cart_en),
        .int_q    (int_q),
        .cart_q   (cart_q),
        .rdata    (rdata)
    );

    AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!int_ce_n && cart_en)); // R1
    AST_FOUR_INT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == VB_FOUR) |-> int_ce_n); // R2
    AST_SINGLE_CART_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == VB_SINGLE) |-> !cart_en); // R3
    AST_PAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (vaddr[13:8] == PAL_PAGE) |-> (int_ce_n && !cart_en)); // R4
    AST_IDLE_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> (rdata == IDLE_BYTE)); // R9
    AST_DESEL_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && int_ce_n && !cart_en) |=> (rdata == IDLE_BYTE)); // R9

endmodule

// File: tb/vbd_top_tb_top.sv
module vbd_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic [13:0] vaddr = '0;
    logic        rd = 1'b0;
    logic        wr = 1'b0;
    logic [7:0]  wdata = '0;

    logic        a_ice_n, a_cen, b_ice_n, b_cen;
    logic [10:0] a_iaddr, b_iaddr;
    logic [12:0] a_caddr;
    logic [13:0] b_caddr;
    logic [7:0]  a_rdata, b_rdata;

    int n_chk = 0;
    int n_fail = 0;
    int cur_mode = 0;
    bit done = 0;

    logic [7:0] int_sh [2048];
    logic [7:0] cart_sh [8192];

    typedef struct {
        logic [7:0] exp_a;
        logic [7:0] exp_b;
        string      tag;
    } item_t;
    item_t sb_q[$];

    always #4 clk = ~clk;

    vbd_top dut_i (
        .clk(clk), .rst_n(rst_n), .mode(mode), .vaddr(vaddr), .rd(rd), .wr(wr),
        .wdata(wdata), .int_ce_n(a_ice_n), .cart_en(a_cen), .int_addr(a_iaddr),
        .cart_addr(a_caddr), .rdata(a_rdata)
    );

    vbd_top #(.CART_KB(16), .CART_IS_RAM(1'b0)) dut_rom_i (
        .clk(clk), .rst_n(rst_n), .mode(mode), .vaddr(vaddr), .rd(rd), .wr(wr),
        .wdata(wdata), .int_ce_n(b_ice_n), .cart_en(b_cen), .int_addr(b_iaddr),
        .cart_addr(b_caddr), .rdata(b_rdata)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic void ref_dec(int m, int a, output bit ice_n, output bit cen);
        bit pal = (((a >> 8) & 63) == 63);
        bit names = ((a >> 13) & 1) == 1;
        case (m)
            1: begin ice_n = 1'b1; cen = !pal; end
            2: begin ice_n = pal; cen = 1'b0; end
            default: begin ice_n = !names || pal; cen = !names; end
        endcase
    endfunction

    function automatic logic [7:0] rom_ref(int a);
        return 8'(a & 255) ^ 8'((a >> 8) & 63);
    endfunction

    function automatic logic [7:0] ref_rd(bit rom, int m, int a);
        bit ice_n, cen;
        ref_dec(m, a, ice_n, cen);
        if (!ice_n) return int_sh[a & 2047];
        if (cen) return rom ? rom_ref(a & 16383) : cart_sh[a & 8191];
        return 8'hFF;
    endfunction

    task automatic op(int a, bit r, bit w, logic [7:0] d, string tag);
        item_t it;
        bit ice_n, cen;
        @(negedge clk);
        vaddr = 14'(a); rd = r; wr = w; wdata = d;
        it.exp_a = r ? ref_rd(1'b0, cur_mode, a) : 8'hFF;
        it.exp_b = r ? ref_rd(1'b1, cur_mode, a) : 8'hFF;
        it.tag = tag;
        sb_q.push_back(it);
        if (w && !r) begin
            ref_dec(cur_mode, a, ice_n, cen);
            if (!ice_n) int_sh[a & 2047] = d;
            if (cen) cart_sh[a & 8191] = d;
        end
    endtask

    task automatic set_mode(int m);
        op(0, 1'b0, 1'b0, 8'h00, "R9");
        cur_mode = m;
        mode = 2'(m);
    endtask

    // Monitor: pops one expected item per cycle, after the edge.
    always @(posedge clk) begin
        #2;
        if (sb_q.size() != 0) begin
            item_t it;
            it = sb_q.pop_front();
            chk(it.tag, "rdata ram build", a_rdata, it.exp_a);
            chk(it.tag, "rdata rom build", b_rdata, it.exp_b);
        end
    end

    initial begin
        #(150000 * 8);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // Reset state: idle byte and split decode of address 0.
        chk("R9", "reset rdata", a_rdata, 8'hFF);
        chk("R9", "reset rdata rom", b_rdata, 8'hFF);
        chk("R1", "reset cart_en", a_cen, 1'b1);
        chk("R1", "reset int_ce_n", a_ice_n, 1'b1);
        rst_n = 1'b1;

        // Full decode sweep, every mode code, both builds.
        for (int m = 0; m < 4; m++) begin
            @(negedge clk);
            mode = 2'(m);
            for (int a = 0; a < 16384; a++) begin
                bit ice_n, cen;
                string rq;
                vaddr = 14'(a);
                #1;
                ref_dec(m, a, ice_n, cen);
                rq = (((a >> 8) & 63) == 63) ? "R4" :
                     (m == 1) ? "R2" : (m == 2) ? "R3" : (m == 3) ? "R7" : "R1";
                chk(rq, "enables", {a_ice_n, a_cen, b_ice_n, b_cen},
                    {28'd0, ice_n, cen, ice_n, cen});
                chk("R5 R6", "addresses", {a_iaddr, a_caddr, b_caddr[7:0]},
                    {11'(a), 13'(a), 8'(a)});
                if (b_caddr !== 14'(a)) chk("R6", "rom cart_addr", b_caddr, 14'(a));
            end
        end

        // Split mode: data paths, mirroring, palette, strobes.
        set_mode(0);
        op(16'h0010, 0, 1, 8'hA1, "R10");
        op(16'h1FFF, 0, 1, 8'hB2, "R10");
        op(16'h2000, 0, 1, 8'hC3, "R10");
        op(16'h2400, 0, 1, 8'hD4, "R10");
        op(16'h2705, 0, 1, 8'h5A, "R10");
        op(16'h2010, 0, 1, 8'h11, "R10");
        op(16'h3F05, 0, 1, 8'hEE, "R4");
        op(16'h0010, 1, 0, 8'h00, "R8");
        op(16'h1FFF, 1, 0, 8'h00, "R8");
        op(16'h2000, 1, 0, 8'h00, "R8");
        op(16'h2800, 1, 0, 8'h00, "R5");
        op(16'h2C00, 1, 0, 8'h00, "R5");
        op(16'h2705, 1, 0, 8'h00, "R4");
        op(16'h3F05, 1, 0, 8'h00, "R4");
        op(16'h2000, 0, 0, 8'h00, "R9");
        op(16'h0010, 1, 1, 8'h3C, "R10");
        op(16'h0010, 1, 0, 8'h00, "R10");

        // Four-screen: cartridge answers the name region, 8KB repeats.
        set_mode(1);
        op(16'h2010, 0, 1, 8'h77, "R2");
        op(16'h3000, 0, 1, 8'h99, "R2");
        op(16'h3F10, 0, 1, 8'h66, "R4");
        op(16'h0010, 1, 0, 8'h00, "R6");
        op(16'h2010, 1, 0, 8'h00, "R6");
        op(16'h1000, 1, 0, 8'h00, "R6");
        op(16'h3F10, 1, 0, 8'h00, "R4");

        // Back to split: internal RAM untouched by four-screen writes.
        set_mode(0);
        op(16'h2010, 1, 0, 8'h00, "R2");
        op(16'h0010, 1, 0, 8'h00, "R6");

        // Single-chip: internal RAM answers both regions.
        set_mode(2);
        op(16'h0123, 0, 1, 8'h42, "R3");
        op(16'h2123, 1, 0, 8'h00, "R3");
        op(16'h3123, 1, 0, 8'h00, "R5");
        op(16'h0010, 1, 0, 8'h00, "R3");

        // Reserved code behaves as split.
        set_mode(3);
        op(16'h2000, 1, 0, 8'h00, "R7");
        op(16'h0010, 1, 0, 8'h00, "R7");
        op(16'h0123, 1, 0, 8'h00, "R7");
        op(16'h0000, 0, 0, 8'h00, "R9");

        repeat (4) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule